// File: doc/BRIEF.md
# Register Indirection Table Builder

This block turns a small set of sparse key-value configuration entries into two dense lookup tables of 32 rows each. One table serves integer registers and the other serves floating-point registers. Each entry names a register number as it appears in an opcode and says how that register is to be treated. The treatment gives the physical start register, an element width code, whether the register is a vector, and whether its elements are packed SIMD.

Decode logic presents a register number and an integer/FP selector on the lookup port. It gets back the redirected start register and the three attributes in the same cycle. Any write to an entry clears both tables and rebuilds them. The rebuild applies one entry per cycle, from the lowest index to the highest. While it runs, the busy output is high and the lookup port gives the neutral scalar answer.

Top module: `regmap_table`

## Requirements
- R1: After synchronous active-low reset, busy is low and every lookup returns the opcode register unchanged, with width code 0 and the vector and packed flags clear.
- R2: A write (wr_en high) stores wr_data in the entry selected by wr_idx. The bit layout of wr_data is:
  - bit 0 chooses the table (0 integer, 1 FP)
  - bits 5:1 hold the key register
  - bits 10:6 hold the target start register
  - bits 12:11 hold the width code
  - bit 13 is the vector flag
  - bit 14 is the packed flag
  - bit 15 is the bank bit
- R3: Busy rises on the edge that takes a write. It stays high for exactly 16 cycles and then falls by itself. It never rises without a write.
- R4: Once busy is low, a lookup of a table and register named by an applied entry returns that entry's target register, width code, vector flag and packed flag. Width codes are passed through unchanged: 0 default, 1 half, 2 eight-bit, 3 sixteen-bit.
- R5: A row that no applied entry names reads as cleared: the opcode register comes back unchanged and all flags are zero. This also holds for a row that was set before the latest rebuild and is no longer named.
- R6: The table bit of an entry decides which table it fills. An integer entry has no effect on an FP lookup of the same register number, and the reverse also holds.
- R7: When two applied entries name the same table and key, the one with the higher index wins.
- R8: An entry with bank bit 1 is reserved and is not applied to either table.
- R9: A write while busy is high restarts the rebuild, so busy stays high for 16 cycles after the last write.
- R10: While busy is high, every lookup returns the cleared-row answer of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Index of the entry being written |
| wr_data | input | 16 | Entry contents, layout in R2 |
| busy | output | 1 | High while the tables are being rebuilt |
| lk_fp | input | 1 | Lookup table select: 0 integer, 1 FP |
| lk_reg | input | 5 | Opcode register number to look up |
| lk_target | output | 5 | Redirected physical start register |
| lk_ew | output | 2 | Element width code |
| lk_vec | output | 1 | Register is treated as a vector |
| lk_simd | output | 1 | Elements are packed SIMD |

## Verification
The assertions take for granted three things about the inputs: wr_idx always names an existing entry, reset is held for at least one edge, and wr_en is a clean one-cycle strobe sampled on the rising edge. The bench keeps within these limits in three ways. It writes only indices 0 to 15. It changes every input on the falling edge. It holds reset for several cycles before arming its comparisons. It also sweeps all 64 lookup combinations continuously, so every row is read back both while a rebuild is in flight and after it settles.

// File: rtl/regmap_pkg.sv
// Shared types for the register indirection table.
// Assumes a 5-bit architectural register number (32 rows per table).
package regmap_pkg;
    localparam int RNUM_W   = 5;
    localparam int NUM_ARCH = 1 << RNUM_W;

    typedef enum logic [1:0] {
        EW_DEFAULT = 2'd0,
        EW_HALF    = 2'd1,
        EW_8       = 2'd2,
        EW_16      = 2'd3
    } ew_e;

    // Configuration entry; fp sits in bit 0, bank in the top bit.
    typedef struct packed {
        logic              bank;
        logic              simd;
        logic              vec;
        ew_e               ew;
        logic [RNUM_W-1:0] target;
        logic [RNUM_W-1:0] key;
        logic              fp;
    } entry_t;

    // One expanded table row; used marks a row written since clearing.
    typedef struct packed {
        logic              used;
        logic              simd;
        logic              vec;
        ew_e               ew;
        logic [RNUM_W-1:0] target;
    } row_t;

    localparam int ENTRY_W = $bits(entry_t);
endpackage

// File: rtl/regmap_seq.sv
// Entry store and rebuild sequencer.
// Holds the configuration entries. Every write restarts a walk that
// presents one entry per cycle, in index order, to the tables.
// Assumes wr_idx is always below N_ENTRIES.
module regmap_seq
    import regmap_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic               busy,
    output logic               tbl_clr,
    output logic               apply_en,
    output entry_t             apply_entry
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

    entry_t           entries [N_ENTRIES];
    logic [IDX_W-1:0] cnt;

    // Store entries and step the rebuild pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) entries[i] <= '0;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (wr_en) begin
            entries[wr_idx] <= entry_t'(wr_data);
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) busy <= 1'b0;
        end
    end

    // Present the current entry; reserved-bank entries are skipped.
    always_comb begin
        apply_entry = entries[cnt];
        tbl_clr     = wr_en;
        apply_en    = busy && !wr_en && !apply_entry.bank;
    end
endmodule

// File: rtl/regmap_bank.sv
// One expanded lookup table (integer or FP).
// Clears every row in one cycle, writes one row per cycle and reads one row
// combinationally. Clear has priority over a row write.
module regmap_bank
    import regmap_pkg::*;
#(
    parameter int ROWS = NUM_ARCH,
    localparam int KEY_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [KEY_W-1:0] wr_key,
    input  row_t             wr_row,
    input  logic [KEY_W-1:0] rd_key,
    output row_t             rd_row
);
    row_t rows [ROWS];

    // Clear or update the table rows.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < ROWS; i++) rows[i] <= '0;
        end else if (wr) begin
            rows[wr_key] <= wr_row;
        end
    end

    // Combinational row read.
    always_comb rd_row = rows[rd_key];
endmodule

// File: rtl/regmap_table.sv
// Register indirection table, top level.
// Expands the configuration entries into an integer table and an FP table,
// and answers register lookups from them. While a rebuild runs, and for rows
// no entry names, the lookup gives the scalar identity mapping.
module regmap_table
    import regmap_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES),
    localparam int N_FILES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic               busy,
    input  logic               lk_fp,
    input  logic [RNUM_W-1:0]  lk_reg,
    output logic [RNUM_W-1:0]  lk_target,
    output logic [1:0]         lk_ew,
    output logic               lk_vec,
    output logic               lk_simd
);
    logic   tbl_clr;
    logic   apply_en;
    entry_t apply_entry;
    row_t   new_row;
    row_t   rd_rows [N_FILES];
    row_t   sel_row;

    regmap_seq #(.N_ENTRIES(N_ENTRIES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .busy       (busy),
        .tbl_clr    (tbl_clr),
        .apply_en   (apply_en),
        .apply_entry(apply_entry)
    );

    // Build the row image carried by the entry being applied.
    always_comb begin
        new_row.used   = 1'b1;
        new_row.simd   = apply_entry.simd;
        new_row.vec    = apply_entry.vec;
        new_row.ew     = apply_entry.ew;
        new_row.target = apply_entry.target;
    end

    for (genvar f = 0; f < N_FILES; f++) begin : g_file
        regmap_bank #(.ROWS(NUM_ARCH)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (tbl_clr),
            .wr    (apply_en && (apply_entry.fp == f[0])),
            .wr_key(apply_entry.key),
            .wr_row(new_row),
            .rd_key(lk_reg),
            .rd_row(rd_rows[f])
        );
    end

    // Pick the table and fall back to identity when busy or unmapped.
    always_comb begin
        sel_row = rd_rows[lk_fp];
        if (busy || !sel_row.used) begin
            lk_target = lk_reg;
            lk_ew     = EW_DEFAULT;
            lk_vec    = 1'b0;
            lk_simd   = 1'b0;
        end else begin
            lk_target = sel_row.target;
            lk_ew     = sel_row.ew;
            lk_vec    = sel_row.vec;
            lk_simd   = sel_row.simd;
        end
    end
endmodule

// File: rtl/regmap_table_chk.sv
// Protocol checker for regmap_table, observing ports only.
// Tracks the number of busy cycles since the last write with its own counter.
module regmap_table_chk #(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [15:0]      wr_data,
    input logic             busy,
    input logic             lk_fp,
    input logic [4:0]       lk_reg,
    input logic [4:0]       lk_target,
    input logic [1:0]       lk_ew,
    input logic             lk_vec,
    input logic             lk_simd
);
    int unsigned since;

    // Count busy cycles since the most recent write.
    always_ff @(posedge clk) begin
        if (!rst_n)      since <= 0;
        else if (wr_en)  since <= 0;
        else if (busy)   since <= since + 1;
    end

    AST_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> busy); // R9

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && since < N_ENTRIES - 1) |=> busy); // R3

    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && since == N_ENTRIES - 1 && !wr_en) |=> !busy); // R3

    AST_NO_SELF_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_en) |=> !busy); // R3

    AST_HOLDOFF_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lk_target == lk_reg && lk_ew == 2'd0 && !lk_vec && !lk_simd)); // R10
endmodule

bind regmap_table regmap_table_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .busy(busy), .lk_fp(lk_fp), .lk_reg(lk_reg),
    .lk_target(lk_target), .lk_ew(lk_ew), .lk_vec(lk_vec), .lk_simd(lk_simd)
);

// File: tb/regmap_table_test.sv
// Bench for regmap_table: behavioural reference compared on every clock.
module regmap_table_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        busy;
    logic        lk_fp = 1'b0;
    logic [4:0]  lk_reg = '0;
    logic [4:0]  lk_target;
    logic [1:0]  lk_ew;
    logic        lk_vec, lk_simd;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    bit    armed = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    logic [15:0] m_entry [16];
    int          m_busy = 0;
    logic [5:0]  sweep = '0;

    regmap_table uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .busy(busy), .lk_fp(lk_fp), .lk_reg(lk_reg),
        .lk_target(lk_target), .lk_ew(lk_ew), .lk_vec(lk_vec), .lk_simd(lk_simd)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] mk(input bit fp, input int key, input int tgt,
                                       input int ew, input bit vec, input bit simd,
                                       input bit bank);
        logic [15:0] e;
        e[0]     = fp;
        e[5:1]   = key[4:0];
        e[10:6]  = tgt[4:0];
        e[12:11] = ew[1:0];
        e[13]    = vec;
        e[14]    = simd;
        e[15]    = bank;
        return e;
    endfunction

    // Reference model state update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_entry[i] = '0;
            m_busy = 0;
        end else if (wr_en) begin
            m_entry[wr_idx] = wr_data;
            m_busy = 16;
        end else if (m_busy > 0) begin
            m_busy = m_busy - 1;
        end
    end

    // Compare on the falling edge, then advance the lookup sweep.
    always @(negedge clk) begin
        logic [4:0] et;
        logic [1:0] eew;
        logic       ev, es, eb;
        string      tag;
        cycles++;
        if (armed && !done) begin
            et = lk_reg; eew = 2'd0; ev = 1'b0; es = 1'b0;
            if (m_busy == 0) begin
                for (int i = 0; i < 16; i++) begin
                    if (!m_entry[i][15] && m_entry[i][0] == lk_fp &&
                        m_entry[i][5:1] == lk_reg) begin
                        et  = m_entry[i][10:6];
                        eew = m_entry[i][12:11];
                        ev  = m_entry[i][13];
                        es  = m_entry[i][14];
                    end
                end
            end
            eb  = (m_busy > 0);
            tag = eb ? "R10" : cur_req;
            vectors++;
            if (busy !== eb) begin
                miscompares++;
                $display("FAIL R3 busy actual %0b expected %0b", busy, eb);
            end else if (lk_target !== et || lk_ew !== eew || lk_vec !== ev || lk_simd !== es) begin
                miscompares++;
                $display("FAIL %s fp=%0b reg=%0d actual t=%0d ew=%0d v=%0b s=%0b expected t=%0d ew=%0d v=%0b s=%0b",
                         tag, lk_fp, lk_reg, lk_target, lk_ew, lk_vec, lk_simd, et, eew, ev, es);
            end
        end
        sweep  <= sweep + 1'b1;
        lk_fp  <= sweep[5];
        lk_reg <= sweep[4:0];
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog R3 actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic put(input int idx, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx[3:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (80) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        armed = 1'b1;
        cur_req = "R1";
        settle();

        cur_req = "R4";
        put(0, mk(0, 3, 17, 0, 1, 0, 0));
        put(1, mk(1, 7, 12, 1, 1, 1, 0));
        put(2, mk(0, 30, 4, 2, 0, 1, 0));
        put(3, mk(1, 0, 31, 3, 1, 0, 0));
        settle();

        cur_req = "R6";
        put(4, mk(0, 5, 9, 2, 1, 0, 0));
        settle();

        cur_req = "R7";
        put(5, mk(0, 11, 20, 1, 1, 0, 0));
        put(12, mk(0, 11, 22, 3, 0, 1, 0));
        settle();

        cur_req = "R8";
        put(6, mk(1, 14, 2, 2, 1, 1, 1));
        put(7, mk(0, 3, 1, 1, 0, 0, 1));
        settle();

        cur_req = "R5";
        put(0, mk(1, 21, 6, 0, 0, 0, 0));
        settle();

        cur_req = "R9";
        put(8, mk(0, 16, 8, 2, 1, 1, 0));
        repeat (9) @(negedge clk);
        put(9, mk(1, 16, 24, 1, 1, 0, 0));
        repeat (5) @(negedge clk);
        put(10, mk(0, 25, 13, 3, 1, 1, 0));
        settle();

        cur_req = "R2";
        for (int i = 0; i < 16; i++) begin
            put(i, 16'($urandom));
            repeat (6) @(negedge clk);
        end
        settle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule